// File: doc/BRIEF.md
# Interrupt Register and Vector Dispatch

This block sits next to a simple CPU sequencer and handles interrupt entry and exit. Every clock cycle it watches a vector of request lines, one per bus port. A device raises the line whose index equals its port number, and that number is the interrupt code. The highest code seen is held in a pending-code register. Code zero means that nothing is pending.

The sequencer pulses `boundary` once an instruction has finished and before the next fetch starts. If a nonzero code is pending at that moment, the block dispatches:
- It pushes the sequencer's current program counter and instruction register onto a last-in-first-out stack.
- It clears the pending register.
- It looks up the handler start address in a 16-entry vector table, using the code as the index, and presents that address for loading into the program counter, all in the same cycle.

A `ret_req` pulse pops the most recently saved frame back to the sequencer. The vector table is filled through a valid/ready configuration port. A write completes in the cycle where `cfg_valid` and `cfg_ready` are both high. `cfg_ready` is low only in a dispatch cycle, so the table never changes in the cycle it is read. A writer that sees `cfg_ready` low must hold its index and address stable until it sees ready high.

Top module: `irq_vector_dispatch`

## Requirements
- R1: After reset, `pend_code` is 0, `stack_depth` is 0, `stack_overflow` is 0, `vec_valid` and `restore_valid` are 0, and every vector-table entry is 0.
- R2: In each cycle with no dispatch, `pend_code` becomes the larger of its current value and the highest index k (k ≥ 1) with `irq_req[k]` high. `irq_req[0]` has no effect.
- R3: `vec_valid` is high exactly in cycles where `boundary` is high, `pend_code` is nonzero and `ret_req` is low. In such a cycle `vec_addr` equals the table entry at index `pend_code`.
- R4: In the cycle after a dispatch, `pend_code` equals the highest request index present in the dispatch cycle, or 0 if there was none. A request arriving during the clear is kept, even if it is lower than the code being serviced.
- R5: A dispatch with fewer than 8 saved frames pushes {`cur_pc`, `cur_ir`} and raises `stack_depth` by one.
- R6: `ret_req` with a nonempty stack sets `restore_valid` in the same cycle. `restore_pc` and `restore_ir` then carry the most recently pushed frame, and `stack_depth` drops by one. `ret_req` with an empty stack gives `restore_valid` low and leaves the depth at 0.
- R7: A dispatch with 8 frames saved still loads the vector and clears the code, but writes no frame. `stack_depth` stays 8, `stack_overflow` goes high and stays high until reset, and the 8 saved frames come back intact.
- R8: A configuration write with `cfg_valid` and `cfg_ready` both high stores `cfg_addr` at entry `cfg_index`. `cfg_ready` is low in dispatch cycles, and no write is taken in those cycles.
- R9: When `ret_req` and `boundary` are both high, the return is served, no dispatch happens, and the pending code is kept for a later boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NCODES | Request lines; bit k set means port k requests service |
| boundary | input | 1 | Instruction finished, next fetch not yet begun |
| cur_pc | input | PC_W | Sequencer program counter, to be saved |
| cur_ir | input | IR_W | Sequencer instruction register, to be saved |
| ret_req | input | 1 | Return from handler, pop one frame |
| cfg_valid | input | 1 | Configuration write offered |
| cfg_ready | output | 1 | Configuration write accepted this cycle |
| cfg_index | input | CODE_W | Vector-table entry to write |
| cfg_addr | input | PC_W | Handler start address to store |
| pend_code | output | CODE_W | Pending interrupt code, 0 when none |
| vec_valid | output | 1 | Load `vec_addr` into the program counter |
| vec_addr | output | PC_W | Handler start address for the pending code |
| restore_valid | output | 1 | Load the restored frame into PC and IR |
| restore_pc | output | PC_W | Restored program counter |
| restore_ir | output | IR_W | Restored instruction register |
| stack_depth | output | DEPTH_W | Frames currently saved |
| stack_overflow | output | 1 | Sticky: a push found the stack full |

## Verification
The assertions take for granted that the sequencer never pulses `boundary` or `ret_req` while in reset. They also assume that a push and a pop are never requested together. The top guarantees this second point by letting a return take precedence. The stimulus changes every input shortly after a rising edge and holds it for a whole cycle. It offers configuration writes only while checking `cfg_ready`, and it reaches a full stack only by counting its own dispatches. Every expected address, frame and code is derived arithmetically from the code index and the push order.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  typedef enum logic [1:0] {
    STK_IDLE = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2
  } stk_op_e;
endpackage

// File: rtl/irqd_capture.sv
module irqd_capture #(
  parameter int NCODES = 16,
  localparam int CODE_W = $clog2(NCODES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCODES-1:0] req,
  input  logic              clear,
  output logic [CODE_W-1:0] code_q
);
  logic [CODE_W-1:0] top_req;

  always_comb begin
    top_req = '0;
    for (int i = 1; i < NCODES; i++) begin
      if (req[i]) top_req = CODE_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (clear) begin
      code_q <= top_req;
    end else if (top_req > code_q) begin
      code_q <= top_req;
    end
  end

  // R2: without a clear the held code never decreases
  a_r2_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> code_q >= $past(code_q));

  // R4: a clear with no fresh request empties the register
  a_r4_clear_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && req[NCODES-1:1] == '0) |=> code_q == '0);
endmodule

// File: rtl/irqd_vector_table.sv
module irqd_vector_table #(
  parameter int NCODES = 16,
  parameter int PC_W   = 16,
  localparam int CODE_W = $clog2(NCODES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_idx,
  input  logic [PC_W-1:0]   wr_data,
  input  logic [CODE_W-1:0] rd_idx,
  output logic [PC_W-1:0]   rd_data
);
  logic [PC_W-1:0] entry [NCODES];

  for (genvar g = 0; g < NCODES; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        entry[g] <= '0;
      end else if (wr_en && wr_idx == CODE_W'(g)) begin
        entry[g] <= wr_data;
      end
    end
  end

  assign rd_data = entry[rd_idx];

  // R8: an accepted write is visible at its index the cycle after
  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> entry[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/irqd_state_stack.sv
module irqd_state_stack
  import irqd_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PC_W  = 16,
  parameter int IR_W  = 16,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int DEPTH_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  stk_op_e            op,
  input  logic [PC_W-1:0]    push_pc,
  input  logic [IR_W-1:0]    push_ir,
  output logic [PC_W-1:0]    top_pc,
  output logic [IR_W-1:0]    top_ir,
  output logic [DEPTH_W-1:0] depth,
  output logic               empty,
  output logic               overflow
);
  logic [PC_W-1:0]    slot_pc [DEPTH];
  logic [IR_W-1:0]    slot_ir [DEPTH];
  logic               full;
  logic [DEPTH_W-1:0] top_pos;

  assign full    = (depth == DEPTH_W'(DEPTH));
  assign empty   = (depth == '0);
  assign top_pos = depth - DEPTH_W'(1);
  assign top_pc  = slot_pc[top_pos[PTR_W-1:0]];
  assign top_ir  = slot_ir[top_pos[PTR_W-1:0]];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_pc[g] <= '0;
        slot_ir[g] <= '0;
      end else if (op == STK_PUSH && !full && depth == DEPTH_W'(g)) begin
        slot_pc[g] <= push_pc;
        slot_ir[g] <= push_ir;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth    <= '0;
      overflow <= 1'b0;
    end else begin
      case (op)
        STK_PUSH: begin
          if (full) overflow <= 1'b1;
          else      depth    <= depth + DEPTH_W'(1);
        end
        STK_POP: begin
          if (!empty) depth <= depth - DEPTH_W'(1);
        end
        default: ;
      endcase
    end
  end

  // R5: a push with room grows the stack by one
  a_r5_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (op == STK_PUSH && !full) |=> depth == $past(depth) + DEPTH_W'(1));

  // R7: a push on a full stack keeps the depth and flags overflow
  a_r7_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (op == STK_PUSH && full) |=> (depth == DEPTH_W'(DEPTH) && overflow));

  // R7: overflow is sticky
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R6: popping an empty stack leaves it empty
  a_r6_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (op == STK_POP && empty) |=> depth == '0);
endmodule

// File: rtl/irq_vector_dispatch.sv
module irq_vector_dispatch
  import irqd_pkg::*;
#(
  parameter int NCODES = 16,
  parameter int DEPTH  = 8,
  parameter int PC_W   = 16,
  parameter int IR_W   = 16,
  localparam int CODE_W  = $clog2(NCODES),
  localparam int DEPTH_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCODES-1:0]  irq_req,
  input  logic               boundary,
  input  logic [PC_W-1:0]    cur_pc,
  input  logic [IR_W-1:0]    cur_ir,
  input  logic               ret_req,
  input  logic               cfg_valid,
  output logic               cfg_ready,
  input  logic [CODE_W-1:0]  cfg_index,
  input  logic [PC_W-1:0]    cfg_addr,
  output logic [CODE_W-1:0]  pend_code,
  output logic               vec_valid,
  output logic [PC_W-1:0]    vec_addr,
  output logic               restore_valid,
  output logic [PC_W-1:0]    restore_pc,
  output logic [IR_W-1:0]    restore_ir,
  output logic [DEPTH_W-1:0] stack_depth,
  output logic               stack_overflow
);
  logic    dispatch;
  logic    stk_empty;
  stk_op_e stk_op;

  assign dispatch      = boundary && (pend_code != '0) && !ret_req;
  assign restore_valid = ret_req && !stk_empty;
  assign vec_valid     = dispatch;
  assign cfg_ready     = !dispatch;

  always_comb begin
    if (ret_req)       stk_op = STK_POP;
    else if (dispatch) stk_op = STK_PUSH;
    else               stk_op = STK_IDLE;
  end

  irqd_capture #(.NCODES(NCODES)) u_capture (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (irq_req),
    .clear  (dispatch),
    .code_q (pend_code)
  );

  irqd_vector_table #(.NCODES(NCODES), .PC_W(PC_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_valid && cfg_ready),
    .wr_idx  (cfg_index),
    .wr_data (cfg_addr),
    .rd_idx  (pend_code),
    .rd_data (vec_addr)
  );

  irqd_state_stack #(.DEPTH(DEPTH), .PC_W(PC_W), .IR_W(IR_W)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (stk_op),
    .push_pc  (cur_pc),
    .push_ir  (cur_ir),
    .top_pc   (restore_pc),
    .top_ir   (restore_ir),
    .depth    (stack_depth),
    .empty    (stk_empty),
    .overflow (stack_overflow)
  );

  // R4: a dispatch with no request in flight leaves nothing pending
  a_r4_dispatch_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && irq_req[NCODES-1:1] == '0) |=> pend_code == '0);

  // R9: a return alongside a boundary keeps the pending code
  a_r9_ret_keeps_code: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && boundary && pend_code != '0) |=> pend_code >= $past(pend_code));

  // R5: a dispatch with room saves one frame
  a_r5_dispatch_pushes: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && stack_depth < DEPTH_W'(DEPTH)) |=> stack_depth == $past(stack_depth) + DEPTH_W'(1));

  // R6: a served return removes one frame
  a_r6_restore_pops: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid |=> stack_depth == $past(stack_depth) - DEPTH_W'(1));
endmodule

// File: tb/irq_vector_dispatch_test.sv
module irq_vector_dispatch_test;
  localparam int NCODES = 16;
  localparam int DEPTH  = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_req = '0;
  logic        boundary = 1'b0;
  logic [15:0] cur_pc = '0;
  logic [15:0] cur_ir = '0;
  logic        ret_req = 1'b0;
  logic        cfg_valid = 1'b0;
  logic        cfg_ready;
  logic [3:0]  cfg_index = '0;
  logic [15:0] cfg_addr = '0;
  logic [3:0]  pend_code;
  logic        vec_valid;
  logic [15:0] vec_addr;
  logic        restore_valid;
  logic [15:0] restore_pc;
  logic [15:0] restore_ir;
  logic [3:0]  stack_depth;
  logic        stack_overflow;

  int runs = 0;
  int fails = 0;

  always #2 clk = ~clk;

  irq_vector_dispatch uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .boundary(boundary),
    .cur_pc(cur_pc), .cur_ir(cur_ir), .ret_req(ret_req),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_index(cfg_index),
    .cfg_addr(cfg_addr), .pend_code(pend_code), .vec_valid(vec_valid),
    .vec_addr(vec_addr), .restore_valid(restore_valid),
    .restore_pc(restore_pc), .restore_ir(restore_ir),
    .stack_depth(stack_depth), .stack_overflow(stack_overflow)
  );

  function automatic logic [15:0] hvec(int c);
    return 16'h1000 + 16'(c) * 16'h0123;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    irq_req = '0; boundary = 0; ret_req = 0; cfg_valid = 0;
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    report();
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    // R1 reset state
    check(pend_code == 0, "R1 pend", pend_code, 0);
    check(stack_depth == 0, "R1 depth", stack_depth, 0);
    check(stack_overflow == 0, "R1 ovf", stack_overflow, 0);
    check(vec_valid == 0 && restore_valid == 0, "R1 valids", vec_valid, 0);
    // R1 table starts at zero: dispatch code 5 before programming
    irq_req = 16'h0020; tick(); idle();
    boundary = 1; cur_pc = 16'h0055; #1;
    check(vec_valid && vec_addr == 0, "R1 table zero", vec_addr, 0);
    tick(); idle();
    ret_req = 1; #1; tick(); idle();

    // R8 program every entry
    for (int c = 0; c < NCODES; c++) begin
      cfg_valid = 1; cfg_index = 4'(c); cfg_addr = hvec(c); #1;
      check(cfg_ready == 1, "R8 ready", cfg_ready, 1);
      tick();
    end
    idle();

    // R2/R3/R4/R5/R6 sweep over every code
    for (int c = 1; c < NCODES; c++) begin
      irq_req = 16'(1) << c; tick(); idle();
      check(pend_code == 4'(c), "R2 latch", pend_code, c);
      #1;
      check(vec_valid == 0, "R3 no boundary", vec_valid, 0);
      tick();
      check(pend_code == 4'(c), "R3 held", pend_code, c);
      boundary = 1; cur_pc = 16'h4000 + 16'(c); cur_ir = 16'hA500 ^ 16'(c); #1;
      check(vec_valid == 1 && vec_addr == hvec(c), "R3 vector", vec_addr, hvec(c));
      tick(); idle();
      check(pend_code == 0, "R4 cleared", pend_code, 0);
      check(stack_depth == 1, "R5 push", stack_depth, 1);
      ret_req = 1; #1;
      check(restore_valid && restore_pc == 16'h4000 + 16'(c), "R6 pc", restore_pc, 16'h4000 + c);
      check(restore_ir == (16'hA500 ^ 16'(c)), "R6 ir", restore_ir, 16'hA500 ^ c);
      tick(); idle();
      check(stack_depth == 0, "R6 depth", stack_depth, 0);
    end

    // R2 priority over every pair, then max with held value
    for (int a = 1; a < NCODES; a++) begin
      for (int b = a + 1; b < NCODES; b++) begin
        irq_req = (16'(1) << a) | (16'(1) << b) | 16'h0001; tick(); idle();
        check(pend_code == 4'(b), "R2 pair", pend_code, b);
        irq_req = 16'(1) << a; tick(); idle();
        check(pend_code == 4'(b), "R2 lower kept out", pend_code, b);
        boundary = 1; #1; tick(); idle();
      end
    end
    irq_req = 16'h0001; tick(); idle();
    check(pend_code == 0, "R2 bit0 ignored", pend_code, 0);
    ret_req = 1;
    for (int k = 0; k < 120; k++) tick();
    idle();
    check(stack_depth == 0, "R6 drained", stack_depth, 0);

    // R4 new code wins during clear (higher, then lower)
    irq_req = 16'h0008; tick(); idle();
    boundary = 1; irq_req = 16'h0080; #1;
    check(vec_addr == hvec(3), "R4 serviced 3", vec_addr, hvec(3));
    tick(); idle();
    check(pend_code == 7, "R4 new wins", pend_code, 7);
    boundary = 1; irq_req = 16'h0004; tick(); idle();
    check(pend_code == 2, "R4 lower kept", pend_code, 2);
    boundary = 1; tick(); idle();
    ret_req = 1; tick(); tick(); tick(); idle();

    // R9 return and boundary together
    irq_req = 16'h0200; tick(); idle();
    boundary = 1; cur_pc = 16'h0900; tick(); idle();
    irq_req = 16'h0010; tick(); idle();
    boundary = 1; ret_req = 1; #1;
    check(vec_valid == 0, "R9 no dispatch", vec_valid, 0);
    check(restore_valid && restore_pc == 16'h0900, "R9 restore", restore_pc, 16'h0900);
    tick(); idle();
    check(pend_code == 4 && stack_depth == 0, "R9 code kept", pend_code, 4);
    // R8 write blocked during dispatch
    boundary = 1; cfg_valid = 1; cfg_index = 4'd4; cfg_addr = 16'hDEAD; #1;
    check(cfg_ready == 0, "R8 ready low", cfg_ready, 0);
    tick(); idle();
    ret_req = 1; tick(); idle();
    irq_req = 16'h0010; tick(); idle();
    boundary = 1; #1;
    check(vec_addr == hvec(4), "R8 write dropped", vec_addr, hvec(4));
    tick(); idle();
    ret_req = 1; tick(); idle();

    // R7 fill the stack, then overflow
    for (int n = 1; n <= DEPTH + 1; n++) begin
      irq_req = 16'h0002; tick(); idle();
      boundary = 1; cur_pc = 16'h7000 + 16'(n); cur_ir = 16'h0100 * 16'(n); #1;
      check(vec_valid && vec_addr == hvec(1), "R7 vector", vec_addr, hvec(1));
      tick(); idle();
      check(stack_depth == 4'(n > DEPTH ? DEPTH : n), "R7 depth", stack_depth, n);
    end
    check(stack_overflow == 1, "R7 overflow", stack_overflow, 1);
    check(pend_code == 0, "R7 code cleared", pend_code, 0);
    for (int n = DEPTH; n >= 1; n--) begin
      ret_req = 1; #1;
      check(restore_valid && restore_pc == 16'h7000 + 16'(n), "R7 lifo pc", restore_pc, 16'h7000 + n);
      check(restore_ir == 16'h0100 * 16'(n), "R7 lifo ir", restore_ir, 16'h0100 * n);
      tick(); idle();
    end
    ret_req = 1; #1;
    check(restore_valid == 0, "R6 empty pop", restore_valid, 0);
    tick(); idle();
    check(stack_depth == 0 && stack_overflow == 1, "R7 sticky", stack_overflow, 1);
    report();
  end
endmodule